// File: doc/BRIEF.md
# Guarded Watchdog Timer

The block is a watchdog timer that counts pulses of a slow clock-enable tick and signals a timeout when software stops restarting it. On a timeout it can raise an interrupt, request a system reset, or do both in turn. In the two-stage behaviour the first timeout raises the interrupt and turns the interrupt behaviour off. If software does not re-arm it, the next timeout requests the reset. The timeout period is picked by a 4-bit select code, and each code doubles the period of the one below it.

Software reaches the block through one 8-bit control word that can be written and read back. The reset-enable bit and the period select are guarded. They only take a new value from a write made within a short window, and that window opens after a separate unlock write. A strap input stands for an always-on fuse. While it is high the watchdog runs and the reset-enable bit cannot be cleared.

Control word layout: bit 0 is the timeout flag (write one to clear), bit 1 is interrupt enable, bit 2 is reset enable, bit 3 is the unlock request (it reads back as "window open"), and bits 7:4 are the period select.

Top module: `wdt_guarded`

## Requirements
- R1: After reset the control word reads 0x00 and `irq_o`, `rst_req_o` and `timeout_o` are low.
- R2: With select code c, a timeout occurs after 2^(BASE_LOG2+min(c, NUM_CODES-1)) tick pulses, counted from a restart. Clock cycles with `tick_i` low do not advance the count, and codes at or above NUM_CODES give the longest period.
- R3: A pulse on `kick_i` restarts the count from zero, so the next timeout comes a full period after the kick.
- R4: Bits 2 and 7:4 change only through a write accepted while the window is open. A write with bits 3 and 2 both set, made while the window is closed, opens the window for the next UNLOCK_CYCLES clock cycles and leaves bits 2 and 7:4 unchanged. Any write made inside the window closes it.
- R5: Bit 1 (interrupt enable) takes the written value on any write, with no unlock needed.
- R6: A timeout while bit 1 is set raises the flag, and `irq_o` follows the flag.
- R7: A timeout while reset is enabled and bit 1 is clear gives a one-cycle pulse on `rst_req_o`.
- R8: A timeout while both bit 1 and reset enable are set raises the flag and clears bit 1, and it requests no reset. The following timeout then requests the reset.
- R9: The flag clears when a one is written to bit 0, or when `irq_ack_i` is pulsed.
- R10: While `force_on_i` is high, bit 2 reads one, a write cannot clear it, and the counter runs.
- R11: When bits 1 and 2 are both clear and `force_on_i` is low, the counter stops and no timeout occurs.
- R12: Every timeout gives exactly one cycle of `timeout_o`, whatever the behaviour selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow time-base enable, one pulse per tick |
| kick_i | input | 1 | Restart strobe for the tick counter |
| force_on_i | input | 1 | Strap that keeps the watchdog running with reset enabled |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| rd_data_o | output | 8 | Control word readback |
| irq_o | output | 1 | Interrupt request (level, follows the flag) |
| rst_req_o | output | 1 | One-cycle system reset request |
| timeout_o | output | 1 | One-cycle pulse on every timeout |

## Verification
The bench builds the block with BASE_LOG2 = 2, NUM_CODES = 10 and UNLOCK_CYCLES = 4. With these values the periods run from 4 to 2048 ticks. That is short enough to sweep all sixteen select codes, including the six codes above the table, in both interrupt mode and reset mode, and to measure each period to the exact cycle. The small unlock window lets the bench test a configuration write on the last cycle inside the window and on the first cycle after it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Control word field positions.
  localparam int FLAG_BIT = 0;
  localparam int IEN_BIT  = 1;
  localparam int REN_BIT  = 2;
  localparam int UNL_BIT  = 3;
  localparam int PSEL_LSB = 4;
  localparam int PSEL_W   = 4;

  // Base-2 logarithm of the period in ticks for a select code.
  // Codes beyond the table saturate at the longest period.
  function automatic int unsigned period_log2(input logic [PSEL_W-1:0] code,
                                              input int unsigned base_log2,
                                              input int unsigned n_codes);
    int unsigned c;
    c = 32'(code);
    if (c >= n_codes) c = n_codes - 1;
    return base_log2 + c;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_LOG2 = 11,
  parameter int NUM_CODES = 10,
  parameter int CNT_W     = BASE_LOG2 + NUM_CODES - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       tick,
  input  logic                       kick,
  input  logic [wdt_pkg::PSEL_W-1:0] psel,
  output logic                       tmo
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [CNT_W:0]   lim;
  logic [CNT_W:0]   lim_m1;

  always_comb begin
    lim    = (CNT_W+1)'(1) << wdt_pkg::period_log2(psel, BASE_LOG2, NUM_CODES);
    lim_m1 = lim - 1'b1;
    last   = lim_m1[CNT_W-1:0];
  end

  // The compare is >= so that a shorter period selected mid-count still ends at once.
  assign tmo = run && tick && !kick && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || kick) cnt <= '0;
    else if (tick)         cnt <= tmo ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic consume,
  output logic win_open
);
  localparam int W = $clog2(UNLOCK_CYCLES + 1);
  logic [W-1:0] cnt;

  assign win_open = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (open_req)   cnt <= W'(UNLOCK_CYCLES);
    else if (consume)    cnt <= '0;
    else if (win_open)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic                       win_open,
  input  logic                       tmo,
  input  logic                       irq_ack,
  input  logic                       force_on,
  output logic                       unlock_req,
  output logic                       cfg_wr,
  output logic                       int_en,
  output logic                       rst_en,
  output logic [wdt_pkg::PSEL_W-1:0] psel,
  output logic                       flag,
  output logic                       rst_pulse,
  output logic                       tmo_pulse
);
  import wdt_pkg::*;

  logic rst_arm, fire_irq, fire_rst, drop_ien;

  assign unlock_req = wr_en && !win_open && wr_data[UNL_BIT] && wr_data[REN_BIT];
  assign cfg_wr     = wr_en && win_open;
  assign rst_arm    = rst_en || force_on;
  assign fire_irq   = tmo && int_en;
  assign fire_rst   = tmo && rst_arm && !int_en;
  assign drop_ien   = tmo && int_en && rst_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      int_en    <= 1'b0;
      rst_en    <= 1'b0;
      psel      <= '0;
      rst_pulse <= 1'b0;
      tmo_pulse <= 1'b0;
    end else begin
      if (fire_irq)                                      flag <= 1'b1;
      else if ((wr_en && wr_data[FLAG_BIT]) || irq_ack)  flag <= 1'b0;

      if (drop_ien)   int_en <= 1'b0;
      else if (wr_en) int_en <= wr_data[IEN_BIT];

      if (force_on)    rst_en <= 1'b1;
      else if (cfg_wr) rst_en <= wr_data[REN_BIT];

      if (cfg_wr) psel <= wr_data[PSEL_LSB +: PSEL_W];

      rst_pulse <= fire_rst;
      tmo_pulse <= tmo;
    end
  end
endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded #(
  parameter int BASE_LOG2     = 11,
  parameter int NUM_CODES     = 10,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       force_on_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       irq_ack_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       timeout_o
);
  import wdt_pkg::*;

  localparam int CNT_W = BASE_LOG2 + NUM_CODES - 1;

  // Named internal events, also observed by the bound checker.
  logic              tmo_evt;
  logic              win_open;
  logic              unlock_req;
  logic              cfg_wr;
  logic              int_en;
  logic              rst_en;
  logic [PSEL_W-1:0] psel;
  logic              flag;
  logic              run;

  assign run = int_en || rst_en || force_on_i;

  wdt_prescaler #(
    .BASE_LOG2(BASE_LOG2),
    .NUM_CODES(NUM_CODES),
    .CNT_W    (CNT_W)
  ) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick_i),
    .kick (kick_i),
    .psel (psel),
    .tmo  (tmo_evt)
  );

  wdt_unlock #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_req(unlock_req),
    .consume (cfg_wr),
    .win_open(win_open)
  );

  wdt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_data   (wr_data_i),
    .win_open  (win_open),
    .tmo       (tmo_evt),
    .irq_ack   (irq_ack_i),
    .force_on  (force_on_i),
    .unlock_req(unlock_req),
    .cfg_wr    (cfg_wr),
    .int_en    (int_en),
    .rst_en    (rst_en),
    .psel      (psel),
    .flag      (flag),
    .rst_pulse (rst_req_o),
    .tmo_pulse (timeout_o)
  );

  assign rd_data_o = {psel, win_open, rst_en, int_en, flag};
  assign irq_o     = flag;
endmodule

// File: rtl/wdt_guarded_chk.sv
module wdt_guarded_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       force_on_i,
  input logic       tmo_evt,
  input logic       win_open,
  input logic       int_en,
  input logic       rst_en,
  input logic [3:0] psel,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       timeout_o
);
  // R4
  psel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(psel) |-> $past(win_open));

  // R4
  ren_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_en) |-> $past(win_open));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> timeout_o);

  // R7
  rst_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> timeout_o);

  // R8
  two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tmo_evt && int_en && (rst_en || force_on_i)) |-> (!int_en && irq_o && !rst_req_o));

  // R10
  force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_on_i) |-> rst_en);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(int_en || rst_en || force_on_i)) |-> !timeout_o);

  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
endmodule

bind wdt_guarded wdt_guarded_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .force_on_i(force_on_i),
  .tmo_evt   (tmo_evt),
  .win_open  (win_open),
  .int_en    (int_en),
  .rst_en    (rst_en),
  .psel      (psel),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .timeout_o (timeout_o)
);

// File: tb/tb_wdt_guarded.sv
module tb_wdt_guarded;
  localparam int B  = 2;
  localparam int NC = 10;
  localparam int UW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       kick_i = 1'b0;
  logic       force_on_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       irq_ack_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o, rst_req_o, timeout_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdt_guarded #(.BASE_LOG2(B), .NUM_CODES(NC), .UNLOCK_CYCLES(UW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .force_on_i(force_on_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .irq_ack_i(irq_ack_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected period: doubling from 2^B, saturating at the last table code.
  function automatic int exp_period(input int code);
    int p = 1;
    for (int i = 0; i < B; i++) p = p * 2;
    for (int i = 0; i < code && i < NC - 1; i++) p = p * 2;
    return p;
  endfunction

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  // Unlock (also clears the flag and sets the interrupt enable), then write the guarded fields.
  task automatic cfg(input int code, input bit ien, input bit ren);
    wr({4'h0, 1'b1, 1'b1, ien, 1'b1});
    wr({4'(code), 1'b0, ren, ien, 1'b1});
  endtask

  // Counts cycles until the chosen output is high: 0 rst_req_o, 1 irq_o, 2 timeout_o.
  task automatic wait_evt(input int which, input int limit, output int n);
    n = 0;
    while (n <= limit) begin
      @(negedge clk);
      n++;
      if ((which == 0 && rst_req_o) || (which == 1 && irq_o) || (which == 2 && timeout_o)) break;
    end
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int n;
    int cnt;
    bit back2back;
    bit prev;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_data_o == 8'h00, "R1", rd_data_o, 0);
    chk(!irq_o && !rst_req_o && !timeout_o, "R1", {irq_o, rst_req_o, timeout_o}, 0);

    // R4 a guarded write without unlock is ignored
    wr(8'h34);
    chk(rd_data_o[7:4] == 4'h0 && !rd_data_o[2], "R4", rd_data_o, 0);
    // R4 the unlock write opens the window and leaves the guarded fields alone
    wr(8'h0C);
    chk(rd_data_o == 8'h08, "R4", rd_data_o, 8'h08);
    idle(3);
    wr(8'h24);
    chk(rd_data_o == 8'h24, "R4", rd_data_o, 8'h24);
    // R4 a write one cycle past the window is rejected
    wr(8'h0C);
    idle(4);
    wr(8'h50);
    chk(rd_data_o == 8'h24, "R4", rd_data_o, 8'h24);
    // R4 a write inside the window closes it
    wr(8'h0C);
    wr(8'h04);
    wr(8'h30);
    chk(rd_data_o == 8'h04, "R4", rd_data_o, 8'h04);

    // R2 R7 reset-mode sweep over every code, ascending
    for (int c = 0; c < 16; c++) begin
      cfg(c, 1'b0, 1'b1);
      kick();
      wait_evt(0, 5000, n);
      chk(n == exp_period(c), "R2", n, exp_period(c));
      chk(!irq_o, "R7", irq_o, 0);
    end

    // R7 the reset request lasts one cycle
    cfg(0, 1'b0, 1'b1);
    kick();
    wait_evt(0, 100, n);
    @(negedge clk);
    chk(!rst_req_o, "R7", rst_req_o, 0);

    // R3 a kick mid-count restarts the period
    cfg(1, 1'b0, 1'b1);
    kick();
    idle(5);
    kick();
    wait_evt(0, 100, n);
    chk(n == 8, "R3", n, 8);

    // R2 cycles with the tick low are ignored
    cfg(0, 1'b0, 1'b1);
    tick_i = 1'b0;
    kick();
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (timeout_o) cnt++;
    end
    chk(cnt == 0, "R2", cnt, 0);
    tick_i = 1'b1;
    wait_evt(0, 100, n);
    chk(n == 4, "R2", n, 4);

    // R6 interrupt-mode sweep
    for (int c = 0; c < 16; c++) begin
      cfg(c, 1'b1, 1'b0);
      kick();
      wait_evt(1, 5000, n);
      chk(n == exp_period(c), "R6", n, exp_period(c));
      chk(!rst_req_o && rd_data_o[1], "R6", {rst_req_o, rd_data_o[1]}, 1);
    end

    // R12 one-cycle timeout pulses, one per period
    cfg(0, 1'b1, 1'b0);
    kick();
    cnt = 0; back2back = 0; prev = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (timeout_o) cnt++;
      if (timeout_o && prev) back2back = 1;
      prev = timeout_o;
    end
    chk(cnt == 10 && !back2back, "R12", cnt, 10);

    // R9 write-one clears the flag
    wr(8'h03);
    chk(!irq_o && !rd_data_o[0], "R9", irq_o, 0);
    // R9 acknowledge clears the flag
    kick();
    wait_evt(1, 100, n);
    irq_ack_i = 1'b1;
    @(negedge clk);
    irq_ack_i = 1'b0;
    chk(!irq_o, "R9", irq_o, 0);

    // R5 interrupt enable writable without unlock
    wr(8'h00);
    chk(!rd_data_o[1], "R5", rd_data_o[1], 0);
    wr(8'h02);
    chk(rd_data_o[1], "R5", rd_data_o[1], 1);

    // R8 two-stage: interrupt first, reset on the next timeout
    cfg(0, 1'b1, 1'b1);
    kick();
    wait_evt(1, 100, n);
    chk(n == 4 && !rst_req_o, "R8", n, 4);
    chk(!rd_data_o[1], "R8", rd_data_o[1], 0);
    wait_evt(0, 100, n);
    chk(n == 4 && irq_o, "R8", n, 4);

    // R11 disabled: no timeouts
    cfg(0, 1'b0, 1'b0);
    chk(rd_data_o[2:1] == 2'b00, "R11", rd_data_o, 0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (timeout_o) cnt++;
    end
    chk(cnt == 0, "R11", cnt, 0);

    // R10 forced enable
    force_on_i = 1'b1;
    @(negedge clk);
    chk(rd_data_o[2], "R10", rd_data_o[2], 1);
    cfg(0, 1'b0, 1'b0);
    chk(rd_data_o[2], "R10", rd_data_o[2], 1);
    kick();
    wait_evt(0, 100, n);
    chk(n == 4, "R10", n, 4);
    force_on_i = 1'b0;
    cfg(0, 1'b0, 1'b0);
    chk(!rd_data_o[2], "R10", rd_data_o[2], 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule